// File: doc/BRIEF.md
# Endpoint Status Flags

This block holds the four sticky status flags of one endpoint in a high-speed USB device controller. The protocol engine sends it single-cycle event pulses: SETUP received, isochronous underflow and overflow, transaction error, STALL sent, NAK sent to an IN token, OUT data received with its CRC result, end of microframe with the number of banks sent and validated, and bank flush. Three of the four flags change meaning with the configured endpoint type and direction. Firmware reads the flags as a 4-bit word and clears them with a write-one-to-clear mask.

An endpoint counts as high-bandwidth isochronous when its type is isochronous, its direction is IN, and its transactions-per-microframe setting is 2 or 3. At the end of each microframe a small checker compares the validated bank count with that setting. The endpoint reset strobe and the endpoint disable strobe each clear every flag in one cycle.

Top module: `ep_status_flags`

## Requirements
- R1: After the synchronous active-low reset, and one cycle after `ep_reset` or `ep_disable` is high, `status` is 0. Either strobe wins over any event or clear in the same cycle.
- R2: `cfg_type` encodes 0 = control, 1 = isochronous, 2 = bulk, 3 = interrupt, and `cfg_dir_in` = 1 marks an IN endpoint. On a control endpoint, `ev_setup` sets `status[0]` in the next cycle.
- R3: On an isochronous endpoint, `status[0]` sets on `ev_iso_underflow` when the endpoint is IN and on `ev_iso_overflow` when it is OUT. On bulk and interrupt endpoints, no event sets `status[0]`.
- R4: `ev_txn_err` sets `status[1]` on every endpoint type.
- R5: On control, bulk and interrupt endpoints, `ev_stall_sent` sets `status[2]` only while `cfg_force_stall` is 1.
- R6: On an isochronous OUT endpoint, `status[2]` takes the value of `ev_out_crc_bad` in the cycle after each `ev_out_rx` and otherwise holds. On this endpoint kind, software clears of bit 2 have no effect.
- R7: The transactions-per-microframe setting `cfg_ntrans` is read as 1 when it is 0. On a high-bandwidth isochronous IN endpoint (isochronous, IN, setting of 2 or 3), `ev_mframe_end` sets `status[2]` when `mf_banks_sent` is not 0 and `mf_banks_valid` is below the setting.
- R8: On an endpoint that is not high-bandwidth, `ev_nak_in` sets `status[3]` and `ev_flush` is ignored. On a high-bandwidth endpoint, `ev_flush` sets `status[3]` and `ev_nak_in` is ignored.
- R9: When `sw_clr_we` is 1, each bit of `status` whose `sw_clr_mask` bit is 1 is cleared in the next cycle. A set event on the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_type | input | 2 | Endpoint type (0 control, 1 isochronous, 2 bulk, 3 interrupt) |
| cfg_dir_in | input | 1 | 1 = IN endpoint |
| cfg_ntrans | input | CNT_W | Transactions per microframe (0 read as 1) |
| cfg_force_stall | input | 1 | Force-stall control is active |
| ev_setup | input | 1 | Valid SETUP packet received |
| ev_iso_underflow | input | 1 | Isochronous IN missed, no bank filled |
| ev_iso_overflow | input | 1 | Isochronous OUT dropped, bank busy |
| ev_txn_err | input | 1 | Data toggle sequencing error |
| ev_stall_sent | input | 1 | STALL handshake sent |
| ev_nak_in | input | 1 | NAK sent to an IN token |
| ev_out_rx | input | 1 | New OUT data received |
| ev_out_crc_bad | input | 1 | CRC result of that OUT data, 1 = bad |
| ev_mframe_end | input | 1 | End of microframe |
| mf_banks_sent | input | CNT_W | Banks sent in the ending microframe |
| mf_banks_valid | input | CNT_W | Banks validated in the ending microframe |
| ev_flush | input | 1 | Unsent banks flushed |
| sw_clr_we | input | 1 | Software clear strobe |
| sw_clr_mask | input | 4 | Write-one-to-clear mask |
| ep_reset | input | 1 | Endpoint reset strobe |
| ep_disable | input | 1 | Endpoint disable strobe |
| status | output | 4 | Flag word |

## Verification
The bench builds the block with the default CNT_W of 2. That width covers every transactions-per-microframe setting (0 through 3, including 0 read as 1) and every bank count that matters for the comparison. So random stimulus reaches the boundary where validated banks equal the setting, as well as the case where no bank was sent. Configuration is redrawn every few dozen cycles, so each flag bit is exercised under all of its meanings and under type changes while flags are already set.

// File: rtl/ep_stat_pkg.sv
// Shared types for the endpoint status flag block.
// Assumes a four-flag status word with fixed bit roles.
package ep_stat_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_t;

    localparam int unsigned NFLAGS   = 4;
    localparam int unsigned F_SETUP  = 0;
    localparam int unsigned F_TXERR  = 1;
    localparam int unsigned F_STALL  = 2;
    localparam int unsigned F_NAK    = 3;

endpackage

// File: rtl/ep_mode_decode.sv
// Turns the endpoint configuration and the engine event pulses into one set
// request per flag, the load control for the CRC bit, and the effective
// clear mask. Purely combinational; assumes the configuration is static
// apart from the rare change made by firmware.
module ep_mode_decode
    import ep_stat_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  logic [1:0]        cfg_type,
    input  logic              cfg_dir_in,
    input  logic [CNT_W-1:0]  cfg_ntrans,
    input  logic              cfg_force_stall,
    input  logic              ev_setup,
    input  logic              ev_iso_underflow,
    input  logic              ev_iso_overflow,
    input  logic              ev_txn_err,
    input  logic              ev_stall_sent,
    input  logic              ev_nak_in,
    input  logic              ev_out_rx,
    input  logic              ev_out_crc_bad,
    input  logic              ev_flush,
    input  logic              ntr_short,
    input  logic              sw_clr_we,
    input  logic [NFLAGS-1:0] sw_clr_mask,
    output logic [CNT_W-1:0]  ntrans_eff,
    output logic              hb_iso_in,
    output logic [NFLAGS-1:0] set_req,
    output logic [NFLAGS-1:0] clr_req,
    output logic [NFLAGS-1:0] load_en,
    output logic [NFLAGS-1:0] load_val
);

    ep_kind_t kind;
    logic     is_iso, iso_in, iso_out;

    // Classify the endpoint from its configuration.
    always_comb begin
        kind       = ep_kind_t'(cfg_type);
        is_iso     = (kind == EP_ISO);
        iso_in     = is_iso && cfg_dir_in;
        iso_out    = is_iso && !cfg_dir_in;
        ntrans_eff = (cfg_ntrans == '0) ? CNT_W'(1) : cfg_ntrans;
        hb_iso_in  = iso_in && (ntrans_eff > CNT_W'(1));
    end

    // Pick the set condition of each shared flag by endpoint kind.
    always_comb begin
        set_req          = '0;
        set_req[F_SETUP] = ((kind == EP_CTRL) && ev_setup)
                         || (iso_in && ev_iso_underflow)
                         || (iso_out && ev_iso_overflow);
        set_req[F_TXERR] = ev_txn_err;
        set_req[F_STALL] = (!is_iso && ev_stall_sent && cfg_force_stall)
                         || (hb_iso_in && ntr_short);
        set_req[F_NAK]   = hb_iso_in ? ev_flush : ev_nak_in;
    end

    // The CRC bit is loaded on OUT data and cannot be cleared by software.
    always_comb begin
        load_en           = '0;
        load_val          = '0;
        load_en[F_STALL]  = iso_out && ev_out_rx;
        load_val[F_STALL] = ev_out_crc_bad;
        clr_req           = sw_clr_we ? sw_clr_mask : '0;
        if (iso_out) begin
            clr_req[F_STALL] = 1'b0;
        end
    end

endmodule

// File: rtl/ep_mframe_check.sv
// End-of-microframe check for high-bandwidth isochronous IN endpoints:
// flags a microframe that sent at least one bank but validated fewer banks
// than the configured transactions per microframe. Assumes the effective
// count is already mapped from 0 to 1.
module ep_mframe_check #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             ev_mframe_end,
    input  logic [CNT_W-1:0] banks_sent,
    input  logic [CNT_W-1:0] banks_valid,
    input  logic [CNT_W-1:0] ntrans_eff,
    output logic             ntr_short
);

    // Compare validated banks with the configured count at microframe end.
    always_comb begin
        ntr_short = ev_mframe_end
                 && (banks_sent != '0)
                 && (banks_valid < ntrans_eff);
    end

endmodule

// File: rtl/ep_flag_cell.sv
// One sticky status flag. Priority, highest first: wipe (endpoint reset or
// disable), load of a status value, set event, software clear.
// Assumes set and clear are already qualified by the decoder.
module ep_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe_i,
    input  logic load_en_i,
    input  logic load_val_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Hold the flag with its fixed priority of updates.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_i) begin
            q_o <= 1'b0;
        end else if (load_en_i) begin
            q_o <= load_val_i;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !wipe_i && !load_en_i) |=> q_o);

    // R1
    wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> !q_o);

    // R9
    clear_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && !load_en_i) |=> !q_o);

endmodule

// File: rtl/ep_status_flags.sv
// Per-endpoint status flag word. Decodes the endpoint kind, runs the
// microframe-end bank check and keeps four sticky flags. Assumes the
// event inputs are single-cycle pulses from the protocol engine and the
// configuration is stable while events arrive.
module ep_status_flags
    import ep_stat_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_type,
    input  logic             cfg_dir_in,
    input  logic [CNT_W-1:0] cfg_ntrans,
    input  logic             cfg_force_stall,
    input  logic             ev_setup,
    input  logic             ev_iso_underflow,
    input  logic             ev_iso_overflow,
    input  logic             ev_txn_err,
    input  logic             ev_stall_sent,
    input  logic             ev_nak_in,
    input  logic             ev_out_rx,
    input  logic             ev_out_crc_bad,
    input  logic             ev_mframe_end,
    input  logic [CNT_W-1:0] mf_banks_sent,
    input  logic [CNT_W-1:0] mf_banks_valid,
    input  logic             ev_flush,
    input  logic             sw_clr_we,
    input  logic [3:0]       sw_clr_mask,
    input  logic             ep_reset,
    input  logic             ep_disable,
    output logic [3:0]       status
);

    logic [CNT_W-1:0]  ntrans_eff;
    logic              hb_iso_in;
    logic              ntr_short;
    logic              wipe;
    logic [NFLAGS-1:0] set_req, clr_req, load_en, load_val;

    // Either endpoint strobe empties the whole word.
    always_comb wipe = ep_reset || ep_disable;

    ep_mframe_check #(.CNT_W(CNT_W)) i_mframe (
        .ev_mframe_end (ev_mframe_end),
        .banks_sent    (mf_banks_sent),
        .banks_valid   (mf_banks_valid),
        .ntrans_eff    (ntrans_eff),
        .ntr_short     (ntr_short)
    );

    ep_mode_decode #(.CNT_W(CNT_W)) i_decode (
        .cfg_type         (cfg_type),
        .cfg_dir_in       (cfg_dir_in),
        .cfg_ntrans       (cfg_ntrans),
        .cfg_force_stall  (cfg_force_stall),
        .ev_setup         (ev_setup),
        .ev_iso_underflow (ev_iso_underflow),
        .ev_iso_overflow  (ev_iso_overflow),
        .ev_txn_err       (ev_txn_err),
        .ev_stall_sent    (ev_stall_sent),
        .ev_nak_in        (ev_nak_in),
        .ev_out_rx        (ev_out_rx),
        .ev_out_crc_bad   (ev_out_crc_bad),
        .ev_flush         (ev_flush),
        .ntr_short        (ntr_short),
        .sw_clr_we        (sw_clr_we),
        .sw_clr_mask      (sw_clr_mask),
        .ntrans_eff       (ntrans_eff),
        .hb_iso_in        (hb_iso_in),
        .set_req          (set_req),
        .clr_req          (clr_req),
        .load_en          (load_en),
        .load_val         (load_val)
    );

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        ep_flag_cell i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .wipe_i     (wipe),
            .load_en_i  (load_en[g]),
            .load_val_i (load_val[g]),
            .set_i      (set_req[g]),
            .clr_i      (clr_req[g]),
            .q_o        (status[g])
        );
    end

    // R3
    no_bulk_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_type == 2'd2 || cfg_type == 2'd3) && !status[0]) |=> !status[0]);

    // R6
    crc_bit_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_type == 2'd1 && !cfg_dir_in && !ev_out_rx && !wipe)
        |=> (status[2] == $past(status[2])));

    // R6
    crc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_type == 2'd1 && !cfg_dir_in && ev_out_rx && !wipe)
        |=> (status[2] == $past(ev_out_crc_bad)));

    // R7
    ntr_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_type == 2'd1 && cfg_dir_in && cfg_ntrans > CNT_W'(1) && ev_mframe_end
         && mf_banks_sent != '0 && mf_banks_valid < cfg_ntrans && !wipe)
        |=> status[2]);

    // R1
    strobe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_reset || ep_disable) |=> (status == 4'd0));

endmodule

// File: tb/test_ep_status_flags.sv
module test_ep_status_flags;

    localparam int CNT_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_type = '0;
    logic cfg_dir_in = 1'b0;
    logic [CNT_W-1:0] cfg_ntrans = '0;
    logic cfg_force_stall = 1'b0;
    logic ev_setup = 0, ev_iso_underflow = 0, ev_iso_overflow = 0, ev_txn_err = 0;
    logic ev_stall_sent = 0, ev_nak_in = 0, ev_out_rx = 0, ev_out_crc_bad = 0;
    logic ev_mframe_end = 0, ev_flush = 0, sw_clr_we = 0, ep_reset = 0, ep_disable = 0;
    logic [CNT_W-1:0] mf_banks_sent = '0, mf_banks_valid = '0;
    logic [3:0] sw_clr_mask = '0;
    logic [3:0] status;

    int n_checks = 0;
    int n_fails = 0;
    logic [3:0] exp_q = '0;

    always #10 clk = ~clk;

    ep_status_flags #(.CNT_W(CNT_W)) i_ep_status_flags (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_dir_in(cfg_dir_in),
        .cfg_ntrans(cfg_ntrans), .cfg_force_stall(cfg_force_stall),
        .ev_setup(ev_setup), .ev_iso_underflow(ev_iso_underflow),
        .ev_iso_overflow(ev_iso_overflow), .ev_txn_err(ev_txn_err),
        .ev_stall_sent(ev_stall_sent), .ev_nak_in(ev_nak_in), .ev_out_rx(ev_out_rx),
        .ev_out_crc_bad(ev_out_crc_bad), .ev_mframe_end(ev_mframe_end),
        .mf_banks_sent(mf_banks_sent), .mf_banks_valid(mf_banks_valid),
        .ev_flush(ev_flush), .sw_clr_we(sw_clr_we), .sw_clr_mask(sw_clr_mask),
        .ep_reset(ep_reset), .ep_disable(ep_disable), .status(status)
    );

    // Expected next flag word from the requirements and the present inputs.
    function automatic logic [3:0] next_exp(input logic [3:0] q);
        logic [3:0] n;
        int nt;
        logic iso, iso_out, hb;
        if (!rst_n || ep_reset || ep_disable) return 4'd0;          // R1
        nt = (cfg_ntrans == 0) ? 1 : int'(cfg_ntrans);              // R7
        iso = (cfg_type == 2'd1);
        iso_out = iso && !cfg_dir_in;
        hb = iso && cfg_dir_in && nt >= 2;
        n = q;
        if (sw_clr_we) n = n & ~(sw_clr_mask & (iso_out ? 4'b1011 : 4'b1111)); // R9 R6
        if ((cfg_type == 2'd0 && ev_setup) || (iso && cfg_dir_in && ev_iso_underflow)
            || (iso_out && ev_iso_overflow)) n[0] = 1'b1;           // R2 R3
        if (ev_txn_err) n[1] = 1'b1;                                // R4
        if (!iso && ev_stall_sent && cfg_force_stall) n[2] = 1'b1;  // R5
        if (hb && ev_mframe_end && mf_banks_sent != 0 && int'(mf_banks_valid) < nt)
            n[2] = 1'b1;                                            // R7
        if (iso_out && ev_out_rx) n[2] = ev_out_crc_bad;            // R6
        if (hb ? ev_flush : ev_nak_in) n[3] = 1'b1;                 // R8
        return n;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        n_checks++;
        if (status !== exp) begin
            n_fails++;
            $display("FAIL %s: status actual %b expected %b", req, status, exp);
        end
    endtask

    task automatic idle();
        ev_setup = 0; ev_iso_underflow = 0; ev_iso_overflow = 0; ev_txn_err = 0;
        ev_stall_sent = 0; ev_nak_in = 0; ev_out_rx = 0; ev_out_crc_bad = 0;
        ev_mframe_end = 0; ev_flush = 0; sw_clr_we = 0; sw_clr_mask = '0;
        ep_reset = 0; ep_disable = 0; mf_banks_sent = '0; mf_banks_valid = '0;
    endtask

    // Apply present inputs for one clock edge, then compare at the falling edge.
    task automatic step(input string req);
        exp_q = next_exp(exp_q);
        @(negedge clk);
        check(req, exp_q);
    endtask

    task automatic set_cfg(input logic [1:0] t, input logic din, input logic [1:0] nt);
        cfg_type = t; cfg_dir_in = din; cfg_ntrans = nt;
    endtask

    task automatic wipe_all();
        idle(); ep_reset = 1; step("R1 endpoint reset"); idle();
    endtask

    initial begin
        #4_000_000;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        @(negedge clk); @(negedge clk);
        exp_q = 4'd0;
        check("R1 reset state", 4'd0);
        rst_n = 1;

        // R2: setup on control, then software clear
        set_cfg(2'd0, 0, 2'd1);
        ev_setup = 1; step("R2 setup sets bit0"); idle();
        sw_clr_we = 1; sw_clr_mask = 4'b0001; step("R9 clear bit0"); idle();

        // R9: set and clear in the same cycle, set wins
        ev_txn_err = 1; sw_clr_we = 1; sw_clr_mask = 4'b0010;
        step("R9 R4 set beats clear"); idle();

        // R5: stall without force-stall does nothing, with it sets
        ev_stall_sent = 1; cfg_force_stall = 0; step("R5 stall ignored"); idle();
        ev_stall_sent = 1; cfg_force_stall = 1; step("R5 stall sets"); idle();
        cfg_force_stall = 0;

        // R1: disable strobe beats events
        ev_nak_in = 1; ep_disable = 1; step("R1 disable wins"); idle();

        // R3: bulk ignores setup and iso events
        set_cfg(2'd2, 1, 2'd1);
        ev_setup = 1; ev_iso_underflow = 1; ev_iso_overflow = 1;
        step("R3 bulk bit0 stays 0"); idle();

        // R6: iso OUT CRC load and read-only against clear
        set_cfg(2'd1, 0, 2'd1);
        ev_out_rx = 1; ev_out_crc_bad = 1; step("R6 crc bad loads 1"); idle();
        sw_clr_we = 1; sw_clr_mask = 4'b0100; step("R6 clear ignored"); idle();
        ev_out_rx = 1; ev_out_crc_bad = 0; step("R6 crc good loads 0"); idle();
        ev_iso_overflow = 1; step("R3 iso OUT overflow"); idle();

        // R7: high-bandwidth boundaries
        wipe_all();
        set_cfg(2'd1, 1, 2'd2);
        ev_mframe_end = 1; mf_banks_sent = 2'd1; mf_banks_valid = 2'd2;
        step("R7 valid equals ntrans no set"); idle();
        ev_mframe_end = 1; mf_banks_sent = 2'd0; mf_banks_valid = 2'd0;
        step("R7 nothing sent no set"); idle();
        ev_mframe_end = 1; mf_banks_sent = 2'd2; mf_banks_valid = 2'd1;
        step("R7 short microframe sets"); idle();

        // R8: on high-bandwidth NAK ignored, flush sets
        ev_nak_in = 1; step("R8 NAK ignored on HB"); idle();
        ev_flush = 1; step("R8 flush sets on HB"); idle();
        wipe_all();
        set_cfg(2'd1, 1, 2'd0);
        ev_flush = 1; step("R8 flush ignored non-HB"); idle();
        ev_mframe_end = 1; mf_banks_sent = 2'd1; mf_banks_valid = 2'd0;
        step("R7 ntrans 0 is not HB"); idle();
        ev_nak_in = 1; step("R8 NAK sets non-HB"); idle();
        ev_iso_underflow = 1; step("R3 iso IN underflow"); idle();

        // Random phase with periodic reconfiguration
        for (int blk = 0; blk < 80; blk++) begin
            set_cfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    2'($urandom_range(0, 3)));
            cfg_force_stall = 1'($urandom_range(0, 1));
            for (int c = 0; c < 40; c++) begin
                ev_setup         = ($urandom_range(0, 7) == 0);
                ev_iso_underflow = ($urandom_range(0, 7) == 0);
                ev_iso_overflow  = ($urandom_range(0, 7) == 0);
                ev_txn_err       = ($urandom_range(0, 9) == 0);
                ev_stall_sent    = ($urandom_range(0, 7) == 0);
                ev_nak_in        = ($urandom_range(0, 7) == 0);
                ev_out_rx        = ($urandom_range(0, 5) == 0);
                ev_out_crc_bad   = 1'($urandom_range(0, 1));
                ev_mframe_end    = ($urandom_range(0, 4) == 0);
                mf_banks_sent    = 2'($urandom_range(0, 3));
                mf_banks_valid   = 2'($urandom_range(0, 3));
                ev_flush         = ($urandom_range(0, 7) == 0);
                sw_clr_we        = ($urandom_range(0, 3) == 0);
                sw_clr_mask      = 4'($urandom_range(0, 15));
                ep_reset         = ($urandom_range(0, 60) == 0);
                ep_disable       = ($urandom_range(0, 60) == 0);
                step("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
            end
            idle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule